// File: doc/BRIEF.md
# Outer-Product Processing-Element Array Multiplier

This block multiplies a short, wide projection matrix A (ROWS x INNER) by one block D (INNER x COLS) of an unfolded tensor, producing Y = A x D in signed fixed-point. The product is built as a sum of outer products. An R_PE x C_PE grid of processing elements does the work. Array row i owns a contiguous slice of the inner dimension, so the matrix operand is cut only along its columns. The tensor block is cut along its rows by the same slices and along its columns into C_PE groups. Every PE therefore stays busy even when A has very few rows.

Each input beat carries, for each array row i, one column of A and the matching row of D. All PEs in array row i share that A column. PE (i,j) takes the j-th column group of the D row. Every PE adds the outer product of its column and row into its local accumulators. After INNER/R_PE beats, an adder tree sums the partials of each array column. The sums are streamed out one element per cycle. A large tensor is handled as a series of blocks. Each block starts with a clear pulse and ends with a done pulse, and the result slices follow one another in block order.

Back-pressure works as follows. A beat is taken only on a cycle where both input valids are high and the block is accumulating. Each input's ready reflects the other input's valid, so the two streams always advance together. An output element holds still until it is accepted.

Top module: `opa_array`

## Requirements
- R1: After reset, `res_valid_o`, `done_o`, `mat_ready_o` and `ten_ready_o` are all low.
- R2: A beat is consumed only while accumulating and only when both valids are high and `clr_i` is low. `mat_ready_o` is high only while `ten_valid_i` is high, and the converse holds for `ten_ready_o`. Neither ready is high while results are being emitted.
- R3: Beat k carries, in `mat_col_i` bits [(i*ROWS+m)*16 +: 16], element A[m][i*KS+k], where KS = INNER/R_PE. It carries, in `ten_row_i` bits [(i*COLS+p)*16 +: 16], element D[i*KS+k][p]. After KS beats the emitted values equal A x D, wrapped to 40 bits.
- R4: Results come out in column-major order: element Y[m][p] is emitted at position p*ROWS+m.
- R5: While `res_valid_o` is high and `res_ready_i` is low, `res_valid_o` stays high and `res_data_o` does not change.
- R6: A `clr_i` pulse zeroes every accumulator, so a block's result does not depend on earlier blocks.
- R7: `done_o` is high for exactly one cycle, in the cycle after the last element of a block is accepted. The block then takes no input until the next `clr_i`.
- R8: Operands are 16-bit two's complement. Products and sums are signed, and full-scale operands of either sign produce exact results.
- R9: Blocks run back to back without reset, and each block's result stream follows the previous one in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Block start: zero accumulators and begin accepting beats |
| mat_valid_i | input | 1 | Matrix column beat valid |
| mat_ready_o | output | 1 | Matrix column beat accepted |
| mat_col_i | input | R_PE*ROWS*16 | One A column per array row |
| ten_valid_i | input | 1 | Tensor row beat valid |
| ten_ready_o | output | 1 | Tensor row beat accepted |
| ten_row_i | input | R_PE*COLS*16 | One D row per array row |
| res_valid_o | output | 1 | Result element valid |
| res_ready_i | input | 1 | Result element accepted |
| res_data_o | output | 40 | Result element, signed |
| done_o | output | 1 | One-cycle pulse after the last element of a block |

## Verification
The hardest case to reach is an output element that waits under back-pressure while the input side keeps offering garbage beats. That case also has to be followed by a fresh block whose sums must not carry anything over from before. The stimulus reaches it by driving valid, nonsense operands during every output phase and during idle gaps, and by stalling `res_ready_i` from a pseudo-random sequence. Several blocks then run back to back with full-scale positive, full-scale negative and mixed operands, and the bench checks each emitted element against a behavioural product in column-major order.

// File: rtl/opa_pkg.sv
package opa_pkg;
  localparam int OPW  = 16;
  localparam int ACCW = 40;
  typedef enum logic [1:0] { ST_IDLE, ST_ACC, ST_OUT } opa_state_e;
endpackage

// File: rtl/opa_pe.sv
module opa_pe #(
  parameter int ROWS = 2,
  parameter int PC   = 2,
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     fire,
  input  logic [ROWS*OPW-1:0]      a_col,
  input  logic [PC*OPW-1:0]        d_row,
  output logic [ROWS*PC*ACCW-1:0]  part
);
  for (genvar m = 0; m < ROWS; m++) begin : g_m
    for (genvar c = 0; c < PC; c++) begin : g_c
      logic signed [2*OPW-1:0] prod;
      logic signed [ACCW-1:0]  acc;
      assign prod = $signed(a_col[m*OPW +: OPW]) * $signed(d_row[c*OPW +: OPW]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     acc <= '0;
        else if (clr)   acc <= '0;
        else if (fire)  acc <= acc + ACCW'(prod);
      end
      assign part[(m*PC+c)*ACCW +: ACCW] = acc;
    end
  end
endmodule

// File: rtl/opa_tree.sv
module opa_tree #(
  parameter int N = 2,
  parameter int W = 40
) (
  input  logic [N*W-1:0] leaves,
  output logic [W-1:0]   sum
);
  localparam int LV = (N > 1) ? $clog2(N) : 0;
  localparam int NP = 1 << LV;
  logic [W-1:0] node [2*NP-1];
  for (genvar l = 0; l < NP; l++) begin : g_leaf
    if (l < N) begin : g_used
      assign node[NP-1+l] = leaves[l*W +: W];
    end else begin : g_pad
      assign node[NP-1+l] = '0;
    end
  end
  for (genvar g = 0; g < NP-1; g++) begin : g_add
    assign node[g] = node[2*g+1] + node[2*g+2];
  end
  assign sum = node[0];
endmodule

// File: rtl/opa_ctrl.sv
module opa_ctrl
  import opa_pkg::*;
#(
  parameter int KS   = 4,
  parameter int ROWS = 2,
  parameter int COLS = 4,
  localparam int BW  = (KS   > 1) ? $clog2(KS)   : 1,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          mat_valid,
  input  logic          ten_valid,
  input  logic          res_ready,
  output logic          mat_ready,
  output logic          ten_ready,
  output logic          fire,
  output logic          res_valid,
  output logic          done,
  output logic [RW-1:0] row_idx,
  output logic [CW-1:0] col_idx
);
  opa_state_e st;
  logic [BW-1:0] beat;
  logic accepting;

  assign accepting = (st == ST_ACC) && !clr;
  assign mat_ready = accepting && ten_valid;
  assign ten_ready = accepting && mat_valid;
  assign fire      = accepting && mat_valid && ten_valid;
  assign res_valid = (st == ST_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      beat    <= '0;
      row_idx <= '0;
      col_idx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr) begin
        st      <= ST_ACC;
        beat    <= '0;
        row_idx <= '0;
        col_idx <= '0;
      end else begin
        case (st)
          ST_ACC: if (fire) begin
            if (beat == BW'(KS-1)) begin
              beat <= '0;
              st   <= ST_OUT;
            end else begin
              beat <= beat + 1'b1;
            end
          end
          ST_OUT: if (res_ready) begin
            if (row_idx == RW'(ROWS-1)) begin
              row_idx <= '0;
              if (col_idx == CW'(COLS-1)) begin
                col_idx <= '0;
                st      <= ST_IDLE;
                done    <= 1'b1;
              end else begin
                col_idx <= col_idx + 1'b1;
              end
            end else begin
              row_idx <= row_idx + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/opa_array.sv
module opa_array
  import opa_pkg::*;
#(
  parameter int R_PE  = 2,
  parameter int C_PE  = 2,
  parameter int ROWS  = 2,
  parameter int INNER = 8,
  parameter int COLS  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       mat_valid_i,
  output logic                       mat_ready_o,
  input  logic [R_PE*ROWS*OPW-1:0]   mat_col_i,
  input  logic                       ten_valid_i,
  output logic                       ten_ready_o,
  input  logic [R_PE*COLS*OPW-1:0]   ten_row_i,
  output logic                       res_valid_o,
  input  logic                       res_ready_i,
  output logic [ACCW-1:0]            res_data_o,
  output logic                       done_o
);
  localparam int KS = INNER / R_PE;
  localparam int PC = COLS / C_PE;
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

  logic          fire;
  logic [RW-1:0] row_idx;
  logic [CW-1:0] col_idx;
  logic [ROWS*PC*ACCW-1:0] parts [R_PE][C_PE];
  logic [R_PE*ACCW-1:0]    tree_in;

  opa_ctrl #(.KS(KS), .ROWS(ROWS), .COLS(COLS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr_i),
    .mat_valid(mat_valid_i), .ten_valid(ten_valid_i), .res_ready(res_ready_i),
    .mat_ready(mat_ready_o), .ten_ready(ten_ready_o), .fire(fire),
    .res_valid(res_valid_o), .done(done_o),
    .row_idx(row_idx), .col_idx(col_idx)
  );

  for (genvar i = 0; i < R_PE; i++) begin : g_row
    for (genvar j = 0; j < C_PE; j++) begin : g_col
      opa_pe #(.ROWS(ROWS), .PC(PC), .OPW(OPW), .ACCW(ACCW)) u_pe (
        .clk(clk), .rst_n(rst_n), .clr(clr_i), .fire(fire),
        .a_col(mat_col_i[i*ROWS*OPW +: ROWS*OPW]),
        .d_row(ten_row_i[(i*COLS + j*PC)*OPW +: PC*OPW]),
        .part(parts[i][j])
      );
    end
  end

  always_comb begin
    int jsel, csel, rsel;
    rsel = int'(row_idx);
    jsel = int'(col_idx) / PC;
    csel = int'(col_idx) % PC;
    tree_in = '0;
    for (int i = 0; i < R_PE; i++) begin
      tree_in[i*ACCW +: ACCW] = parts[i][jsel][(rsel*PC + csel)*ACCW +: ACCW];
    end
  end

  opa_tree #(.N(R_PE), .W(ACCW)) u_tree (
    .leaves(tree_in),
    .sum(res_data_o)
  );
endmodule

// File: rtl/opa_array_chk.sv
module opa_array_chk #(
  parameter int R_PE  = 2,
  parameter int C_PE  = 2,
  parameter int ROWS  = 2,
  parameter int INNER = 8,
  parameter int COLS  = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        clr_i,
  input logic        mat_valid_i,
  input logic        mat_ready_o,
  input logic        ten_valid_i,
  input logic        ten_ready_o,
  input logic        res_valid_o,
  input logic        res_ready_i,
  input logic [39:0] res_data_o,
  input logic        done_o
);
  localparam int KS = INNER / R_PE;
  logic [15:0] beats;
  logic [15:0] emitted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats   <= '0;
      emitted <= '0;
    end else if (clr_i) begin
      beats   <= '0;
      emitted <= '0;
    end else begin
      if (mat_valid_i && mat_ready_o && ten_valid_i && ten_ready_o) beats <= beats + 1'b1;
      if (res_valid_o && res_ready_i) emitted <= emitted + 1'b1;
    end
  end

  // R2
  no_input_while_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> (!mat_ready_o && !ten_ready_o));

  // R3
  full_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid_o) |-> (beats == 16'(KS)));

  // R5
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i && !clr_i) |=> (res_valid_o && $stable(res_data_o)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_after_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (emitted == 16'(ROWS*COLS) && !res_valid_o));
endmodule

bind opa_array opa_array_chk #(
  .R_PE(R_PE), .C_PE(C_PE), .ROWS(ROWS), .INNER(INNER), .COLS(COLS)
) u_chk (.*);

// File: tb/tb_opa_array.sv
`timescale 1ns/1ps
module tb_opa_array;
  localparam int R_PE = 2, C_PE = 2, ROWS = 2, INNER = 8, COLS = 4;
  localparam int KS = INNER / R_PE;
  localparam int NOUT = ROWS * COLS;
  // kind[33:32]: 0 random, 1 all +max, 2 all -max, 3 alternating extremes; seed[31:0]
  localparam logic [33:0] CASES [6] = '{
    {2'd0, 32'h0000_1234}, {2'd1, 32'h0000_0001}, {2'd2, 32'h0000_0002},
    {2'd3, 32'h0000_0003}, {2'd0, 32'h00C0_FFEE}, {2'd0, 32'h0BAD_F00D}
  };

  logic clk = 0, rst_n = 0, clr_i = 0;
  logic mat_valid_i = 0, ten_valid_i = 0, res_ready_i = 0;
  logic [R_PE*ROWS*16-1:0] mat_col_i = '0;
  logic [R_PE*COLS*16-1:0] ten_row_i = '0;
  logic mat_ready_o, ten_ready_o, res_valid_o, done_o;
  logic [39:0] res_data_o;

  int checks = 0, errors = 0;
  int a [ROWS][INNER];
  int d [INNER][COLS];
  logic [39:0] ex [NOUT];
  logic [31:0] lcg;

  always #2.5 clk = ~clk;

  opa_array #(.R_PE(R_PE), .C_PE(C_PE), .ROWS(ROWS), .INNER(INNER), .COLS(COLS)) dut (.*);

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic make_ops(input int kind, input logic [31:0] seed);
    lcg = seed;
    for (int m = 0; m < ROWS; m++)
      for (int n = 0; n < INNER; n++) begin
        lcg = nxt(lcg);
        case (kind)
          1: a[m][n] = 32767;
          2: a[m][n] = -32768;
          3: a[m][n] = ((m + n) % 2 == 0) ? 32767 : -32768;
          default: a[m][n] = int'($signed(lcg[31:16]));
        endcase
      end
    for (int n = 0; n < INNER; n++)
      for (int p = 0; p < COLS; p++) begin
        lcg = nxt(lcg);
        case (kind)
          1: d[n][p] = 32767;
          2: d[n][p] = -32768;
          3: d[n][p] = (p % 2 == 0) ? -32768 : 32767;
          default: d[n][p] = int'($signed(lcg[31:16]));
        endcase
      end
    for (int p = 0; p < COLS; p++)
      for (int m = 0; m < ROWS; m++) begin
        longint s = 0;
        for (int n = 0; n < INNER; n++) s += longint'(a[m][n]) * longint'(d[n][p]);
        ex[p*ROWS + m] = s[39:0];
      end
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_i = 1;
    @(negedge clk); clr_i = 0;
  endtask

  task automatic send_beats();
    for (int k = 0; k < KS; k++) begin
      @(negedge clk);
      for (int i = 0; i < R_PE; i++) begin
        for (int m = 0; m < ROWS; m++) mat_col_i[(i*ROWS+m)*16 +: 16] = 16'(a[m][i*KS+k]);
        for (int p = 0; p < COLS; p++) ten_row_i[(i*COLS+p)*16 +: 16] = 16'(d[i*KS+k][p]);
      end
      mat_valid_i = 1; ten_valid_i = 1;
      #1;
      while (!(mat_ready_o && ten_ready_o)) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    mat_valid_i = 0; ten_valid_i = 0;
  endtask

  // reads one block with optional stalls; input side offers junk that must be ignored
  task automatic read_block(input bit stall, input string tag);
    logic [39:0] held;
    bit pending;
    pending = 0;
    for (int e = 0; e < NOUT; e++) begin
      bit got;
      got = 0;
      while (!got) begin
        @(negedge clk);
        mat_valid_i = 1; ten_valid_i = 1;
        mat_col_i = '1; ten_row_i = '1;
        lcg = nxt(lcg);
        res_ready_i = stall ? lcg[20] : 1'b1;
        #1;
        if (pending) begin
          chk(res_valid_o && res_data_o == held, "R5 held element", res_data_o, held);
          pending = 0;
        end
        if (e == 0) chk(!mat_ready_o && !ten_ready_o, "R2 no input during output", {38'd0, mat_ready_o, ten_ready_o}, 40'd0);
        if (res_valid_o && !res_ready_i) begin held = res_data_o; pending = 1; end
        if (res_valid_o && res_ready_i) begin
          chk(res_data_o == ex[e], {tag, " R3/R4 element"}, res_data_o, ex[e]);
          got = 1;
          @(posedge clk);
        end
      end
    end
    @(negedge clk);
    res_ready_i = 0;
    #1;
    chk(done_o == 1'b1, "R7 done pulse", {39'd0, done_o}, 40'd1);
    @(negedge clk); #1;
    chk(done_o == 1'b0 && !mat_ready_o && !ten_ready_o && !res_valid_o,
        "R7 idle after done", {37'd0, done_o, mat_ready_o, ten_ready_o}, 40'd0);
    mat_valid_i = 0; ten_valid_i = 0;
  endtask

  task automatic run_block(input int kind, input logic [31:0] seed, input bit stall, input string tag);
    make_ops(kind, seed);
    pulse_clr();
    send_beats();
    read_block(stall, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1
    chk(!res_valid_o && !done_o && !mat_ready_o && !ten_ready_o, "R1 reset outputs",
        {36'd0, res_valid_o, done_o, mat_ready_o, ten_ready_o}, 40'd0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!mat_ready_o && !res_valid_o, "R1 idle after reset", {38'd0, mat_ready_o, res_valid_o}, 40'd0);

    // R3 R4 R5 R6 R8 R9: table of blocks run back to back, no reset between them
    for (int t = 0; t < 6; t++) begin
      run_block(int'(CASES[t][33:32]), CASES[t][31:0], t[0], $sformatf("R9 block%0d R8 R6", t));
    end

    // R2: one-sided valid is not consumed
    make_ops(0, 32'h5555_AAAA);
    pulse_clr();
    @(negedge clk);
    mat_valid_i = 1; ten_valid_i = 0; mat_col_i = '1;
    #1;
    chk(!mat_ready_o && ten_ready_o, "R2 ready follows other valid", {38'd0, mat_ready_o, ten_ready_o}, 40'd1);
    @(negedge clk);
    mat_valid_i = 0; ten_valid_i = 1; ten_row_i = '1;
    #1;
    chk(mat_ready_o && !ten_ready_o, "R2 ready follows other valid", {38'd0, mat_ready_o, ten_ready_o}, 40'd2);
    @(negedge clk);
    ten_valid_i = 0;
    send_beats();
    read_block(1'b1, "R2 unpaired beats dropped");

    // R6 R7: junk offered while idle, then a clean block
    @(negedge clk);
    mat_valid_i = 1; ten_valid_i = 1; mat_col_i = '1; ten_row_i = '1;
    repeat (4) @(negedge clk);
    #1;
    chk(!mat_ready_o && !res_valid_o, "R7 idle ignores input", {38'd0, mat_ready_o, res_valid_o}, 40'd0);
    mat_valid_i = 0; ten_valid_i = 0;
    run_block(3, 32'h7, 1'b0, "R6 after idle junk");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule